// File: doc/BRIEF.md
# Interrupt Acknowledge and Running Priority Unit

This unit is the processor-side acknowledge and completion logic of an interrupt controller. It serves one processor. It keeps one active flag per interrupt line. It takes these inputs from neighbouring logic:
- the per-line priority values,
- the ID chosen by the pending-selection search,
- the distributor and processor-interface enable flags.

It exposes a small single-port register interface with four selectors:

| `addr_i` | Read | Write |
|---|---|---|
| 0 | Acknowledge | Ignored |
| 1 | Returns zero | End-of-interrupt |
| 2 | Running priority | Ignored |
| 3 | Error flag in bit 0 | Clears the error flag |

An acknowledge read hands the processor the highest pending ID and moves that interrupt into the active set. The unit reports the acknowledge to its neighbours with a one-cycle pulse carrying the ID. The neighbours respond to the pulse in three ways:
- they clear the pending bit,
- they drop the interrupt request line,
- they run selection again.

An end-of-interrupt write names an ID whose active flag is then cleared. A write naming an ID that is not active is an error. It sets a sticky error flag and changes nothing else.

The running priority is the lowest priority value among active interrupts, or 0xFF when none are active. It is computed combinationally from the active set and the priority inputs. It therefore follows acknowledges, completions and priority changes without delay.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset, every active flag is 0, the running priority is 0xFF, the error flag is 0 and there is no acknowledge pulse.
- R2: A read with `addr_i`=0 while both enables are 1 and `hp_id_i` < NUM_IRQ returns `hp_id_i` on `rdata_o`, with `rvalid_o` high in the next cycle. In that same cycle, the active flag of that ID is set.
- R3: A successful acknowledge raises `ack_done_o` for exactly one cycle, with `ack_id_o` equal to the acknowledged ID, in the cycle after the read.
- R4: If either enable is 0, an acknowledge read returns 1023, leaves every active flag unchanged and raises no pulse.
- R5: If `hp_id_i` is 1023 or not below NUM_IRQ, an acknowledge read returns 1023 and changes no state.
- R6: A write with `addr_i`=1 of an ID whose active flag is set clears that flag in the next cycle.
- R7: A write with `addr_i`=1 of an ID that is not active (including an out-of-range ID) sets the sticky error flag and leaves the active flags unchanged.
- R8: `run_prio_o` is the minimum 8-bit priority over all active interrupts, or 0xFF if none are active.
- R9: `run_prio_o` tracks changes of `prio_i` combinationally, with no clock edge needed.
- R10: Register reads return values in the next cycle:
  - `addr_i`=2 returns the running priority;
  - `addr_i`=3 returns the error flag in bit 0;
  - `addr_i`=1 returns 0.

  A write with `addr_i`=3 clears the error flag. Writes with `addr_i`=0 or 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Distributor enable |
| cpu_en_i | input | 1 | Processor interface enable |
| hp_id_i | input | 10 | Highest pending ID from the selection logic (1023 = none) |
| prio_i | input | NUM_IRQ*8 | Priority of each line, line i in bits [8i+7:8i] |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register selector: 0 acknowledge, 1 end-of-interrupt, 2 running priority, 3 status |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid when rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| ack_done_o | output | 1 | Acknowledge pulse: clear pending, drop the request, reselect |
| ack_id_o | output | 10 | ID carried by the acknowledge pulse |
| active_o | output | NUM_IRQ | Active flag per line |
| run_prio_o | output | 8 | Running priority |
| eoi_err_o | output | 1 | Sticky error flag for completion of an ID that is not active |

## Verification
The hardest state to reach from the ports is several lines active at once with distinct priorities. In that state the running priority must pick the right minimum while completions remove active lines in an arbitrary order.

The bench builds that state with directed acknowledges of chosen IDs. It then mixes in random acknowledges, completions, priority reshuffles and enable toggles. Random completion IDs are often taken from a random ID range, so the error path is also hit while other lines remain active.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam int unsigned ID_W    = 10;
  localparam int unsigned SPUR_ID = 1023;

  typedef enum logic [1:0] {
    SEL_ACK  = 2'd0,
    SEL_EOI  = 2'd1,
    SEL_RPR  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/iau_min_prio.sv
module iau_min_prio #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IRQ-1:0]        active_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0]         min_o
);
  logic [PRIO_W-1:0] chain [NUM_IRQ+1];

  assign chain[0] = '1;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stage
    logic [PRIO_W-1:0] p;
    assign p = prio_i[i*PRIO_W +: PRIO_W];
    assign chain[i+1] = (active_i[i] && (p < chain[i])) ? p : chain[i];

    AST_RP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_i[i] |-> (min_o <= p)); // R8
  end

  assign min_o = chain[NUM_IRQ];

  AST_RP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i == '0) |-> (min_o == '1)); // R8
endmodule

// File: rtl/iau_active_set.sv
module iau_active_set #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned ID_W    = 10,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [ID_W-1:0]    hp_id_i,
  input  logic               ack_rd_i,
  input  logic               eoi_wr_i,
  input  logic [DATA_W-1:0]  eoi_id_i,
  input  logic               err_clr_i,
  output logic               ack_ok_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic               ack_done_o,
  output logic [ID_W-1:0]    ack_id_o,
  output logic               err_o
);
  localparam int unsigned IDX_W = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] active_q;
  logic               done_q, err_q;
  logic [ID_W-1:0]    id_q;
  logic [IDX_W-1:0]   hp_idx, eoi_idx;
  logic               eoi_in, eoi_hit, ack_take;

  assign hp_idx   = hp_id_i[IDX_W-1:0];
  assign eoi_idx  = eoi_id_i[IDX_W-1:0];
  assign ack_ok_o = en_i && (32'(hp_id_i) < NUM_IRQ);
  assign ack_take = ack_rd_i && ack_ok_o;
  assign eoi_in   = 32'(eoi_id_i) < NUM_IRQ;
  assign eoi_hit  = eoi_wr_i && eoi_in && active_q[eoi_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      done_q   <= 1'b0;
      id_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      if (ack_take) active_q[hp_idx]  <= 1'b1;
      if (eoi_hit)  active_q[eoi_idx] <= 1'b0;
      done_q <= ack_take;
      if (ack_take) id_q <= hp_id_i;
      err_q  <= (err_q && !err_clr_i) || (eoi_wr_i && !eoi_hit);
    end
  end

  assign active_o   = active_q;
  assign ack_done_o = done_q;
  assign ack_id_o   = id_q;
  assign err_o      = err_q;

  AST_ACK_SETS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> active_q[id_q[IDX_W-1:0]]); // R2
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd_i && en_i && (32'(hp_id_i) < NUM_IRQ)) |=> done_q && (id_q == $past(hp_id_i))); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd_i && !en_i) |=> ($stable(active_q) && !done_q)); // R4
  AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_hit |=> !active_q[$past(eoi_idx)]); // R6
  AST_EOI_BAD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr_i && !eoi_hit) |=> ($stable(active_q) && err_q)); // R7
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import iau_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dist_en_i,
  input  logic                      cpu_en_i,
  input  logic [ID_W-1:0]           hp_id_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [1:0]                addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o,
  output logic                      ack_done_o,
  output logic [ID_W-1:0]           ack_id_o,
  output logic [NUM_IRQ-1:0]        active_o,
  output logic [PRIO_W-1:0]         run_prio_o,
  output logic                      eoi_err_o
);
  reg_sel_e          sel;
  logic              rd, wr, ack_ok, err;
  logic [DATA_W-1:0] rd_next, rdata_q;
  logic              rvalid_q;
  logic [PRIO_W-1:0] rprio;
  logic [NUM_IRQ-1:0] active;

  assign sel = reg_sel_e'(addr_i);
  assign rd  = req_i && !we_i;
  assign wr  = req_i && we_i;

  iau_active_set #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .DATA_W(DATA_W)) u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (dist_en_i && cpu_en_i),
    .hp_id_i   (hp_id_i),
    .ack_rd_i  (rd && (sel == SEL_ACK)),
    .eoi_wr_i  (wr && (sel == SEL_EOI)),
    .eoi_id_i  (wdata_i),
    .err_clr_i (wr && (sel == SEL_STAT)),
    .ack_ok_o  (ack_ok),
    .active_o  (active),
    .ack_done_o(ack_done_o),
    .ack_id_o  (ack_id_o),
    .err_o     (err)
  );

  iau_min_prio #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_min (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .prio_i  (prio_i),
    .min_o   (rprio)
  );

  always_comb begin
    unique case (sel)
      SEL_ACK:  rd_next = ack_ok ? DATA_W'(hp_id_i) : DATA_W'(SPUR_ID);
      SEL_RPR:  rd_next = DATA_W'(rprio);
      SEL_STAT: rd_next = DATA_W'(err);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_next;
    end
  end

  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign active_o   = active;
  assign run_prio_o = rprio;
  assign eoi_err_o  = err;

  AST_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_q); // R10
  AST_SPUR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (sel == SEL_ACK) && !(dist_en_i && cpu_en_i)) |=> (rdata_q == DATA_W'(SPUR_ID))); // R4
  AST_ACK_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (sel == SEL_ACK)) |=> (rdata_q == DATA_W'(SPUR_ID)) || (rdata_q == DATA_W'(ack_id_o))); // R2
endmodule

// File: tb/irq_ack_unit_test.sv
module irq_ack_unit_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de = 1'b0, ce = 1'b0;
  logic [9:0]  hp = 10'd1023;
  logic [N*8-1:0] prio_flat;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid, ack_done, eoi_err;
  logic [9:0]  ack_id;
  logic [N-1:0] active;
  logic [7:0]  run_prio;

  logic [7:0]  prio_b [N];
  logic [N-1:0] act_m = '0;
  logic        err_m = 1'b0;
  int          nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = prio_b[i];

  irq_ack_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(de), .cpu_en_i(ce), .hp_id_i(hp),
    .prio_i(prio_flat), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .ack_done_o(ack_done), .ack_id_o(ack_id),
    .active_o(active), .run_prio_o(run_prio), .eoi_err_o(eoi_err)
  );

  function automatic logic [7:0] min_prio(logic [N-1:0] a);
    logic [7:0] m = 8'hFF;
    for (int i = 0; i < N; i++) if (a[i] && prio_b[i] < m) m = prio_b[i];
    return m;
  endfunction

  task automatic chk(string req_tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // one register access; model updated from the requirements
  task automatic op(bit r, bit w, logic [1:0] a, int wd, string tag);
    logic [15:0] exp_rd = '0;
    bit exp_rv, exp_ack = 0;
    logic [9:0] exp_id = '0;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = 16'(wd);
    exp_rv = r && !w;
    if (r && !w) begin
      case (a)
        2'd0: begin
          if (de && ce && hp < N) begin
            exp_rd = 16'(hp); exp_ack = 1; exp_id = hp; act_m[hp[4:0]] = 1'b1;
          end else exp_rd = 16'd1023;
        end
        2'd2: exp_rd = 16'(min_prio(act_m));
        2'd3: exp_rd = 16'(err_m);
        default: exp_rd = '0;
      endcase
    end else if (r && w) begin
      if (a == 2'd1) begin
        if (wd < N && act_m[wd]) act_m[wd] = 1'b0;
        else err_m = 1'b1;
      end else if (a == 2'd3) err_m = 1'b0;
    end
    @(posedge clk); #5;
    chk({tag, " rvalid"}, rvalid, exp_rv);
    if (exp_rv) chk({tag, " rdata"}, rdata, exp_rd);
    chk({tag, " ack_done"}, ack_done, exp_ack);
    if (exp_ack) chk({tag, " ack_id"}, ack_id, exp_id);
    chk({tag, " active"}, active, act_m);
    chk({tag, " err"}, eoi_err, err_m);
    chk({tag, " run_prio"}, run_prio, min_prio(act_m));
  endtask

  task automatic idle(string tag);
    op(0, 0, 2'd0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) prio_b[i] = 8'(8'hA0 - i);
    #35 rst_n = 1'b1;
    #10;
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 run_prio", run_prio, 8'hFF);
    chk("R1 err", eoi_err, 0);
    chk("R1 ack_done", ack_done, 0);
    // R4 acknowledge with an enable off
    de = 1; ce = 0; hp = 10'd5;
    op(1, 0, 2'd0, 0, "R4 cpu off");
    de = 0; ce = 1;
    op(1, 0, 2'd0, 0, "R4 dist off");
    de = 1; ce = 1;
    // R5 spurious / out of range
    hp = 10'd1023; op(1, 0, 2'd0, 0, "R5 spurious");
    hp = 10'd40;   op(1, 0, 2'd0, 0, "R5 out of range");
    // R2 R3 acknowledges, R8 running priority
    prio_b[3] = 8'h40; prio_b[9] = 8'h20; prio_b[17] = 8'h60;
    hp = 10'd3;  op(1, 0, 2'd0, 0, "R2 R3 ack 3");
    idle("R3 pulse ends");
    hp = 10'd17; op(1, 0, 2'd0, 0, "R2 ack 17");
    hp = 10'd9;  op(1, 0, 2'd0, 0, "R2 ack 9");
    op(1, 0, 2'd2, 0, "R10 R8 read rpr");
    // R9 live tracking
    @(negedge clk); prio_b[17] = 8'h10; #1;
    chk("R9 live", run_prio, 8'h10);
    // R6 completions
    op(1, 1, 2'd1, 17, "R6 eoi 17");
    op(1, 1, 2'd1, 9, "R6 eoi 9");
    // R7 bad completions
    op(1, 1, 2'd1, 9, "R7 eoi inactive");
    op(1, 0, 2'd3, 0, "R10 read stat");
    op(1, 1, 2'd3, 0, "R10 clear stat");
    op(1, 1, 2'd1, 700, "R7 eoi out of range");
    op(1, 0, 2'd1, 0, "R10 read eoi sel");
    op(1, 1, 2'd0, 0, "R10 write ack ignored");
    op(1, 1, 2'd2, 0, "R10 write rpr ignored");
    op(1, 1, 2'd3, 0, "R10 clear");
    // random mix
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 9);
      de = ($urandom_range(0, 7) != 0);
      ce = ($urandom_range(0, 7) != 0);
      hp = ($urandom_range(0, 9) == 0) ? 10'd1023 : 10'($urandom_range(0, N + 3));
      if ($urandom_range(0, 19) == 0)
        for (int i = 0; i < N; i++) prio_b[i] = 8'($urandom);
      if (sel < 4)       op(1, 0, 2'd0, 0, "R2 R4 R5 rand ack");
      else if (sel < 7)  op(1, 1, 2'd1, $urandom_range(0, N + 2), "R6 R7 rand eoi");
      else if (sel == 7) op(1, 0, 2'($urandom_range(1, 3)), 0, "R10 rand read");
      else if (sel == 8) op(1, 1, 2'($urandom_range(0, 3)), 0, "R10 rand write");
      else               idle("R8 rand idle");
    end
    idle("end");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule